// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave holds low after an interrupted transfer or a reset. A trigger pulse starts a recovery. The block toggles the clock line with legal low and high times. At the end of each high phase it looks at the data line. As soon as the data line reads high, it stops clocking and issues a start condition, so that every slave state machine on the bus begins a new transaction. If the data line is still low after the last permitted clock, the block gives up, sets a fail flag and lets both lines float.

Both lines are driven as open-drain pull enables: 0 pulls the line low and 1 releases it. The real line levels come back through synchronizers. The block measures every interval in system clock cycles. Each timing value exists as a parameter in a standard set and a fast set, and a mode input chooses the set at trigger time. After a successful recovery the block parks with both lines pulled low and pulses done, so that the normal transfer engine can take the bus over in the middle of a started transaction.

Top module: `busrec_seq`

## Requirements
- R1: After reset, and at once while reset is asserted, both pull outputs are 1 (released), and busy_o, done_o and fail_o are 0.
- R2: Each recovery clock pulls the clock line low (scl_pull_n = 0) for exactly the low time of the selected mode, then releases it.
- R3: Each high phase lasts the high time of the selected mode, counted only while the synchronized clock line reads high. With a line that follows at once, the release lasts the high time plus SYNC_STAGES cycles.
- R4: The data line is sampled at the end of every high phase. The first high sample ends the clocking, so the number of pulses equals the index of the first high-phase with the data line released, and is at least one.
- R5: At most MAX_PULSES (9) pulses are issued. If the data line is still low at the end of the last high phase, fail_o goes to 1, both lines are released, busy_o drops and no done pulse occurs.
- R6: After the data line is seen high, both lines stay released for the larger of the bus-free time and the start setup time. The block then pulls the data line low while the clock line stays released, for the start hold time.
- R7: After the start hold time the clock line is also pulled low, done_o is 1 for exactly one cycle, and both lines stay pulled low until the next trigger.
- R8: fast_i = 1 at the trigger selects the fast timing set and 0 selects the standard set. Changes of fast_i during a recovery have no effect on it.
- R9: A start_i pulse while busy_o is 1 is ignored and does not restart or lengthen the pulse sequence.
- R10: fail_o stays 1 until the next accepted trigger and is cleared by that trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Trigger pulse; accepted when not busy |
| fast_i | input | 1 | Timing set select at trigger: 1 fast, 0 standard |
| scl_i | input | 1 | Clock line level (asynchronous) |
| sda_i | input | 1 | Data line level (asynchronous) |
| scl_pull_n | output | 1 | Clock line pull enable, 0 drives low |
| sda_pull_n | output | 1 | Data line pull enable, 0 drives low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse when the start condition is complete |
| fail_o | output | 1 | Data line stuck after the last pulse; held until next trigger |

## Verification
A slave model holds the data line low until it has seen a chosen number of clock rising edges. The recovery is run with that number set to zero, one, several, exactly the pulse limit and beyond the limit, in both timing modes. Zero and one show that at least one pulse is always issued. The counts in the middle show that the block stops on the first high sample and does not stop on a fixed count. The limit and the counts beyond it separate the last successful pulse from the fail path. Each run also measures the low, high, setup and hold intervals against the selected mode. Further runs flip the mode input and poke the trigger in the middle of a recovery, and assert reset in the middle of one.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_LOW,
    RS_HIGH,
    RS_SETUP,
    RS_START,
    RS_PARK
  } rec_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= d_i;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          en_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_we = 1'b1;
      cnt_d  = val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: a stalled count must not move when nothing loads it
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
#(
  parameter int STD_LOW    = 470,
  parameter int STD_HIGH   = 400,
  parameter int STD_BUF    = 470,
  parameter int STD_SU     = 470,
  parameter int STD_HD     = 400,
  parameter int FAST_LOW   = 120,
  parameter int FAST_HIGH  = 60,
  parameter int FAST_BUF   = 120,
  parameter int FAST_SU    = 60,
  parameter int FAST_HD    = 60,
  parameter int MAX_PULSES = 9,
  parameter int TW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fast_i,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_en,
  output logic          scl_pull_n,
  output logic          sda_pull_n,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);

  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES);

  localparam logic [TW-1:0] S_LOW  = TW'(STD_LOW - 1);
  localparam logic [TW-1:0] S_HIGH = TW'(STD_HIGH - 1);
  localparam logic [TW-1:0] S_SET  = TW'(imax(STD_BUF, STD_SU) - 1);
  localparam logic [TW-1:0] S_HOLD = TW'(STD_HD - 1);
  localparam logic [TW-1:0] F_LOW  = TW'(FAST_LOW - 1);
  localparam logic [TW-1:0] F_HIGH = TW'(FAST_HIGH - 1);
  localparam logic [TW-1:0] F_SET  = TW'(imax(FAST_BUF, FAST_SU) - 1);
  localparam logic [TW-1:0] F_HOLD = TW'(FAST_HD - 1);

  rec_state_e    state_q, state_d;
  logic          mode_q, mode_d, mode_we;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          fail_q, fail_d;
  logic          done_q, done_d;
  logic          idle_like;

  assign idle_like = (state_q == RS_IDLE) || (state_q == RS_PARK);

  // next-state and timer control
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    mode_we  = 1'b0;
    pcnt_d   = pcnt_q;
    fail_d   = fail_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_en   = 1'b0;
    unique case (state_q)
      RS_IDLE, RS_PARK: begin
        if (start_i) begin
          state_d  = RS_LOW;
          mode_d   = fast_i;
          mode_we  = 1'b1;
          pcnt_d   = '0;
          fail_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = fast_i ? F_LOW : S_LOW;
        end
      end
      RS_LOW: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d  = RS_HIGH;
          pcnt_d   = pcnt_q + 1'b1;
          tmr_load = 1'b1;
          tmr_val  = mode_q ? F_HIGH : S_HIGH;
        end
      end
      RS_HIGH: begin
        tmr_en = scl_s;
        if (tmr_zero && scl_s) begin
          if (sda_s) begin
            state_d  = RS_SETUP;
            tmr_load = 1'b1;
            tmr_val  = mode_q ? F_SET : S_SET;
          end else if (pcnt_q == LAST_PULSE) begin
            state_d = RS_IDLE;
            fail_d  = 1'b1;
          end else begin
            state_d  = RS_LOW;
            tmr_load = 1'b1;
            tmr_val  = mode_q ? F_LOW : S_LOW;
          end
        end
      end
      RS_SETUP: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d  = RS_START;
          tmr_load = 1'b1;
          tmr_val  = mode_q ? F_HOLD : S_HOLD;
        end
      end
      RS_START: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d = RS_PARK;
          done_d  = 1'b1;
        end
      end
      default: state_d = RS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      mode_q  <= 1'b0;
      pcnt_q  <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mode_we) mode_q <= mode_d;
      pcnt_q  <= pcnt_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign scl_pull_n = !((state_q == RS_LOW)   || (state_q == RS_PARK));
  assign sda_pull_n = !((state_q == RS_START) || (state_q == RS_PARK));
  assign busy_o     = !idle_like;
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: done coincides with both lines parked low
  a_r7_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!scl_pull_n && !sda_pull_n));

  // R5: a failed recovery leaves both lines floating
  a_r5_fail_released: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (scl_pull_n && sda_pull_n && !busy_o));

  // R5: pulse count never passes the limit
  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST_PULSE);

  // R6: the data line is pulled low only while the clock line is released
  a_r6_start_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_n) |-> scl_pull_n);

  // R3: the high phase waits while the clock line reads low
  a_r3_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HIGH && !scl_s) |=> (state_q == RS_HIGH));

  // R8: mode is frozen during a recovery
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mode_q));

  // R9: a trigger while busy does not clear the pulse count
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q != RS_LOW) |=> $stable(pcnt_q));

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int STD_LOW     = 470,
  parameter int STD_HIGH    = 400,
  parameter int STD_BUF     = 470,
  parameter int STD_SU      = 470,
  parameter int STD_HD      = 400,
  parameter int FAST_LOW    = 120,
  parameter int FAST_HIGH   = 60,
  parameter int FAST_BUF    = 120,
  parameter int FAST_SU     = 60,
  parameter int FAST_HD     = 60,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_n,
  output logic sda_pull_n,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);

  localparam int T_STD  = imax(imax(imax(STD_LOW, STD_HIGH), imax(STD_BUF, STD_SU)), STD_HD);
  localparam int T_FAST = imax(imax(imax(FAST_LOW, FAST_HIGH), imax(FAST_BUF, FAST_SU)), FAST_HD);
  localparam int TW     = $clog2(imax(T_STD, T_FAST) + 1);

  logic          rst_n_int;
  logic          scl_s, sda_s;
  logic          tmr_zero, tmr_load, tmr_en;
  logic [TW-1:0] tmr_val;

  // reset: asserted asynchronously, released after two clean edges
  busrec_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_int)
  );

  busrec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n_int), .d_i(scl_i), .q_o(scl_s)
  );

  busrec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n_int), .d_i(sda_i), .q_o(sda_s)
  );

  busrec_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .load_i(tmr_load), .val_i(tmr_val),
    .en_i(tmr_en), .zero_o(tmr_zero)
  );

  busrec_ctrl #(
    .STD_LOW(STD_LOW), .STD_HIGH(STD_HIGH), .STD_BUF(STD_BUF),
    .STD_SU(STD_SU), .STD_HD(STD_HD),
    .FAST_LOW(FAST_LOW), .FAST_HIGH(FAST_HIGH), .FAST_BUF(FAST_BUF),
    .FAST_SU(FAST_SU), .FAST_HD(FAST_HD),
    .MAX_PULSES(MAX_PULSES), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .start_i(start_i), .fast_i(fast_i),
    .scl_s(scl_s), .sda_s(sda_s), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_en(tmr_en),
    .scl_pull_n(scl_pull_n), .sda_pull_n(sda_pull_n),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

endmodule

// File: tb/busrec_seq_test.sv
`timescale 1ns/1ps
module busrec_seq_test;

  localparam int S_LOW = 12, S_HIGH = 10, S_BUF = 12, S_SU = 14, S_HD = 10;
  localparam int F_LOW = 6,  F_HIGH = 4,  F_BUF = 6,  F_SU = 4,  F_HD = 5;
  localparam int SYNC  = 2;
  localparam int NV    = 8;
  // columns: fast, slave stuck edges, expected pulses, expected fail
  localparam int TBL [NV][4] = '{
    '{0, 0, 1, 0}, '{1, 1, 1, 0}, '{0, 3, 3, 0}, '{1, 9, 9, 0},
    '{0, 10, 9, 1}, '{1, 12, 9, 1}, '{1, 4, 4, 0}, '{0, 6, 6, 0}};

  logic clk = 1'b0;
  logic rst_n, start_i, fast_i;
  logic scl_pull_n, sda_pull_n, busy_o, done_o, fail_o;
  logic scl_line, sda_line, slave_sda, slv_clr, mclr;
  int   stuck, seen;
  int   errors = 0, checks = 0, cyc = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  busrec_seq #(
    .STD_LOW(S_LOW), .STD_HIGH(S_HIGH), .STD_BUF(S_BUF), .STD_SU(S_SU), .STD_HD(S_HD),
    .FAST_LOW(F_LOW), .FAST_HIGH(F_HIGH), .FAST_BUF(F_BUF), .FAST_SU(F_SU), .FAST_HD(F_HD),
    .MAX_PULSES(9), .SYNC_STAGES(SYNC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_n(scl_pull_n), .sda_pull_n(sda_pull_n),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  // slave: holds data low until it has seen 'stuck' clock rising edges
  assign scl_line  = scl_pull_n;
  assign slave_sda = (seen >= stuck);
  assign sda_line  = sda_pull_n & slave_sda;
  always @(posedge scl_line or posedge slv_clr)
    if (slv_clr) seen <= 0; else seen <= seen + 1;

  // line monitor, sampled on the falling clock edge
  int rises, lowcnt, hicnt, sdalow, low_w, hi_w, pre_w, hd_w, dones;
  logic p_scl, p_sda;
  always @(negedge clk) begin
    if (mclr) begin
      rises = 0; lowcnt = 0; hicnt = 0; sdalow = 0; low_w = 0;
      hi_w = 0; pre_w = 0; hd_w = 0; dones = 0; p_scl = 1'b1; p_sda = 1'b1;
    end else begin
      if (done_o) dones++;
      if (!scl_pull_n) begin
        if (p_scl) begin
          if (p_sda) hi_w = hicnt; else hd_w = sdalow;
        end
        if (busy_o) lowcnt++;
      end else begin
        if (!p_scl) begin
          rises++; low_w = lowcnt; lowcnt = 0; hicnt = 0; sdalow = 0;
        end
        if (sda_pull_n) hicnt++;
        else begin
          if (p_sda) pre_w = hicnt;
          sdalow++;
        end
      end
      p_scl = scl_pull_n; p_sda = sda_pull_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int fail_at_start;
  bit timed_out;

  task automatic do_run(input int f, input int k, input bit flip, input bit poke);
    stuck = k; slv_clr = 1'b1; mclr = 1'b1; fast_i = f[0];
    @(negedge clk); slv_clr = 1'b0;
    @(negedge clk); mclr = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    fail_at_start = int'(fail_o);
    if (flip) fast_i = ~fast_i;
    timed_out = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (poke && i == 30) start_i = 1'b1;
      if (poke && i == 31) start_i = 1'b0;
      if (!busy_o) begin timed_out = 1'b0; break; end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("run ends (R5)", int'(timed_out), 0);
  endtask

  task automatic check_run(input int f, input int ep, input int ef);
    int lw, hw, sw, hd;
    lw = f ? F_LOW : S_LOW;
    hw = (f ? F_HIGH : S_HIGH) + SYNC;
    sw = f ? ((F_BUF > F_SU) ? F_BUF : F_SU) : ((S_BUF > S_SU) ? S_BUF : S_SU);
    hd = f ? F_HD : S_HD;
    chk("R4 pulse count", rises, ep);
    chk("R5 fail flag", int'(fail_o), ef);
    chk("R7 done pulses", dones, 1 - ef);
    chk("R2 low width", low_w, lw);
    if (ep > 1) chk("R3 high width", hi_w, hw);
    if (ef == 0) begin
      chk("R6 setup before start", pre_w, hw + sw);
      chk("R6 start hold", hd_w, hd);
      chk("R7 parked scl", int'(scl_pull_n), 0);
      chk("R7 parked sda", int'(sda_pull_n), 0);
    end else begin
      chk("R5 released scl", int'(scl_pull_n), 1);
      chk("R5 released sda", int'(sda_pull_n), 1);
      chk("R5 not busy", int'(busy_o), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; fast_i = 1'b0; stuck = 0;
    slv_clr = 1'b1; mclr = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 reset scl", int'(scl_pull_n), 1);
    chk("R1 reset sda", int'(sda_pull_n), 1);
    chk("R1 reset flags", int'({busy_o, done_o, fail_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset busy", int'(busy_o), 0);

    for (int v = 0; v < NV; v++) begin
      do_run(TBL[v][0], TBL[v][1], 1'b0, 1'b0);
      check_run(TBL[v][0], TBL[v][2], TBL[v][3]);
    end

    // R10: fail is held, then cleared by the next trigger
    do_run(0, 11, 1'b0, 1'b0);
    chk("R10 fail held", int'(fail_o), 1);
    repeat (5) @(negedge clk);
    chk("R10 fail still held", int'(fail_o), 1);
    do_run(1, 2, 1'b0, 1'b0);
    chk("R10 fail cleared at trigger", fail_at_start, 0);
    check_run(1, 2, 0);

    // R8: mode input flipped during a fast run, then during a standard run
    do_run(1, 3, 1'b1, 1'b0);
    check_run(1, 3, 0);
    do_run(0, 2, 1'b1, 1'b0);
    check_run(0, 2, 0);

    // R9: trigger poked while busy
    do_run(1, 5, 1'b0, 1'b1);
    check_run(1, 5, 0);

    // R1: reset in the middle of a recovery
    stuck = 20; slv_clr = 1'b1; mclr = 1'b1; fast_i = 1'b0;
    @(negedge clk); slv_clr = 1'b0; mclr = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 busy before mid reset", int'(busy_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset scl", int'(scl_pull_n), 1);
    chk("R1 mid reset sda", int'(sda_pull_n), 1);
    chk("R1 mid reset busy", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule